// File: doc/BRIEF.md
# Per-Cluster CPU Clock Ratio Controller

This block sets the integer ratio between a PLL clock and the clock of each of two CPU clusters. Software reaches it through a simple register bus: each cluster has a divider register, a force register and a request register, and one status register is shared by both clusters. The block produces a one-cycle clock-enable pulse per cluster, once every N PLL cycles, where N is that cluster's active ratio.

A newly written ratio only sits in a shadow copy at first. It becomes active after a handshake. Software writes the ratio, sets the force flag and then raises the request bit. The block switches the active ratio at the next divided-clock period boundary. It clears the cluster's stable flag when it sees the request and sets the flag again one full new period after the switch. Software polls the flag and then clears the request.

Cluster 0 is always present. Cluster 1 can be marked absent by an input pin. While it is absent, its registers are hidden from the bus and its clock enable stays low.

Top module: `cpu_ratio_ctrl`

## Requirements
- R1: Cluster 0 registers sit at these addresses: divider 0x278 with the ratio in bits [5:0], force 0x280 with the flag in bit 24, request 0x284 with the flag in bit 16. Cluster 1 registers are the same, each 0x14 higher. The status register is at 0xC94 and holds the stable flag of cluster c in bit c. Every field reads back the value last written to it.
- R2: Writing a divider register changes only the shadow ratio. The clock-enable period does not change until a reload happens.
- R3: When a cluster's request bit goes from 0 to 1 while its force bit is 1, the shadow ratio is loaded. After that the cluster's clock enable is high for one cycle out of every N cycles, where N is the new ratio.
- R4: The stable flag reads 0 from the cycle after the request edge. It returns to 1 only on a cycle that follows a clock-enable pulse, one full new period after the switch.
- R5: A 0-to-1 request edge while the force bit is 0 is ignored. The period stays the same and the stable flag stays 1.
- R6: Clearing the request bit leaves the stable flag at 1.
- R7: A loaded ratio of 0 acts as 1. A loaded ratio above 32 acts as 32.
- R8: A reload on one cluster leaves the other cluster's period unchanged.
- R9: While `upper_present` is 0, cluster 1's registers and its status bit read 0, writes to its registers are ignored, and its clock enable stays 0.
- R10: After reset both shadow ratios read 1, force and request read 0, both stable flags read 1, and both clock enables are high in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PLL clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upper_present | input | NCLUST-1 | Presence of clusters 1 and up |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| clk_en | output | NCLUST | Per-cluster divided clock-enable pulse |

## Verification
The assertions assume that a request edge is produced only by a bus write, so the request, force and stable signals change only at clock edges that follow a register write. They also assume that software does not raise a request again before the previous reload has finished. The bench always waits for the stable flag, and clears the request, before it starts the next reload on that cluster. Bus writes are one cycle long and are driven on the falling edge, so every request edge is clean.

// File: rtl/cpu_ratio_pkg.sv
package cpu_ratio_pkg;
    localparam int NCLUST_DEF  = 2;
    localparam int DIV_W_DEF   = 6;
    localparam int MAX_DIV_DEF = 32;
    localparam int ADDR_W_DEF  = 12;
    localparam int DATA_W_DEF  = 32;

    // Register layout; the bench and software both depend on these
    localparam int RATIO_ADDR  = 'h278;
    localparam int FORCE_ADDR  = 'h280;
    localparam int REQ_ADDR    = 'h284;
    localparam int STAT_ADDR   = 'hC94;
    localparam int CL_STRIDE   = 'h14;
    localparam int FORCE_BIT   = 24;
    localparam int REQ_BIT     = 16;
    localparam int STAT_BASE   = 0;
    localparam int STAT_STEP   = 1;
endpackage

// File: rtl/cpu_ratio_regs.sv
module cpu_ratio_regs
    import cpu_ratio_pkg::*;
#(
    parameter int NCLUST = NCLUST_DEF,
    parameter int DIV_W  = DIV_W_DEF,
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NCLUST-1:0]             present,
    input  logic [NCLUST-1:0]             stable,
    input  logic                          bus_wr,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [DATA_W-1:0]             bus_wdata,
    output logic [DATA_W-1:0]             bus_rdata,
    output logic [NCLUST-1:0][DIV_W-1:0]  shadow,
    output logic [NCLUST-1:0]             frc,
    output logic [NCLUST-1:0]             req
);
    typedef struct packed {
        logic [NCLUST-1:0][DIV_W-1:0] shd;
        logic [NCLUST-1:0]            frc;
        logic [NCLUST-1:0]            req;
    } reg_st_t;

    reg_st_t st_d, st_q;

    function automatic logic [ADDR_W-1:0] cl_addr(int base, int c);
        return ADDR_W'(base + c * CL_STRIDE);
    endfunction

    always_comb begin
        st_d      = st_q;
        bus_rdata = '0;
        for (int c = 0; c < NCLUST; c++) begin
            if (present[c]) begin
                if (bus_wr && bus_addr == cl_addr(RATIO_ADDR, c))
                    st_d.shd[c] = bus_wdata[DIV_W-1:0];
                if (bus_wr && bus_addr == cl_addr(FORCE_ADDR, c))
                    st_d.frc[c] = bus_wdata[FORCE_BIT];
                if (bus_wr && bus_addr == cl_addr(REQ_ADDR, c))
                    st_d.req[c] = bus_wdata[REQ_BIT];

                if (bus_addr == cl_addr(RATIO_ADDR, c))
                    bus_rdata[DIV_W-1:0] = st_q.shd[c];
                if (bus_addr == cl_addr(FORCE_ADDR, c))
                    bus_rdata[FORCE_BIT] = st_q.frc[c];
                if (bus_addr == cl_addr(REQ_ADDR, c))
                    bus_rdata[REQ_BIT] = st_q.req[c];
                if (bus_addr == ADDR_W'(STAT_ADDR))
                    bus_rdata[STAT_BASE + c * STAT_STEP] = stable[c];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NCLUST; c++)
                st_q.shd[c] <= DIV_W'(1);
            st_q.frc <= '0;
            st_q.req <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign shadow = st_q.shd;
    assign frc    = st_q.frc;
    assign req    = st_q.req;
endmodule

// File: rtl/cpu_ratio_div.sv
module cpu_ratio_div
    import cpu_ratio_pkg::*;
#(
    parameter int DIV_W   = DIV_W_DEF,
    parameter int MAX_DIV = MAX_DIV_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] shadow,
    input  logic             frc,
    input  logic             req,
    output logic             tick,
    output logic             stable
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] act;
        logic [DIV_W-1:0] pdiv;
        logic             pend;
        logic             settle;
        logic             stable;
        logic             req_prev;
    } div_st_t;

    div_st_t st_d, st_q;
    logic    boundary;

    function automatic logic [DIV_W-1:0] clamp_ratio(logic [DIV_W-1:0] v);
        if (v == '0)
            return DIV_W'(1);
        else if (int'(v) > MAX_DIV)
            return DIV_W'(MAX_DIV);
        else
            return v;
    endfunction

    always_comb begin
        st_d          = st_q;
        st_d.req_prev = req;
        boundary      = (st_q.cnt == st_q.act - DIV_W'(1));
        st_d.cnt      = boundary ? '0 : st_q.cnt + DIV_W'(1);

        if (boundary && st_q.settle) begin
            st_d.settle = 1'b0;
            st_d.stable = 1'b1;
        end
        if (boundary && st_q.pend) begin
            st_d.act    = st_q.pdiv;
            st_d.pend   = 1'b0;
            st_d.settle = 1'b1;
        end
        if (req && !st_q.req_prev && frc) begin
            st_d.pend   = 1'b1;
            st_d.pdiv   = clamp_ratio(shadow);
            st_d.stable = 1'b0;
            st_d.settle = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt      <= '0;
            st_q.act      <= DIV_W'(1);
            st_q.pdiv     <= DIV_W'(1);
            st_q.pend     <= 1'b0;
            st_q.settle   <= 1'b0;
            st_q.stable   <= 1'b1;
            st_q.req_prev <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick   = boundary;
    assign stable = st_q.stable;
endmodule

// File: rtl/cpu_ratio_ctrl.sv
module cpu_ratio_ctrl
    import cpu_ratio_pkg::*;
#(
    parameter int NCLUST  = NCLUST_DEF,
    parameter int DIV_W   = DIV_W_DEF,
    parameter int MAX_DIV = MAX_DIV_DEF,
    parameter int ADDR_W  = ADDR_W_DEF,
    parameter int DATA_W  = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCLUST-2:0] upper_present,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCLUST-1:0] clk_en
);
    logic [NCLUST-1:0]            present_w;
    logic [NCLUST-1:0]            stable_w;
    logic [NCLUST-1:0]            tick_w;
    logic [NCLUST-1:0]            frc_w;
    logic [NCLUST-1:0]            req_w;
    logic [NCLUST-1:0][DIV_W-1:0] shadow_w;

    assign present_w = {upper_present, 1'b1};

    cpu_ratio_regs #(
        .NCLUST(NCLUST), .DIV_W(DIV_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .present(present_w), .stable(stable_w),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .shadow(shadow_w), .frc(frc_w), .req(req_w)
    );

    for (genvar c = 0; c < NCLUST; c++) begin : g_cl
        cpu_ratio_div #(.DIV_W(DIV_W), .MAX_DIV(MAX_DIV)) u_div (
            .clk(clk), .rst_n(rst_n), .shadow(shadow_w[c]), .frc(frc_w[c]),
            .req(req_w[c]), .tick(tick_w[c]), .stable(stable_w[c])
        );
        assign clk_en[c] = tick_w[c] & present_w[c];
    end
endmodule

// File: rtl/cpu_ratio_ctrl_chk.sv
module cpu_ratio_ctrl_chk #(
    parameter int NCLUST = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NCLUST-1:0] req,
    input logic [NCLUST-1:0] frc,
    input logic [NCLUST-1:0] stable,
    input logic [NCLUST-1:0] tick
);
    for (genvar i = 0; i < NCLUST; i++) begin : g_chk
        assert_stable_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(req[i]) && frc[i] |=> !stable[i]);
        assert_stable_on_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(stable[i]) |-> $past(tick[i]));
        assert_noforce_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(req[i]) && !frc[i] && stable[i] |=> stable[i]);
        assert_clear_keeps_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(req[i]) && stable[i] |=> stable[i]);
    end
endmodule

bind cpu_ratio_ctrl cpu_ratio_ctrl_chk #(.NCLUST(NCLUST)) u_chk (
    .clk(clk), .rst_n(rst_n), .req(req_w), .frc(frc_w),
    .stable(stable_w), .tick(tick_w)
);

// File: tb/cpu_ratio_ctrl_tb.sv
`timescale 1ns/1ps
module cpu_ratio_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [0:0]  upper_present = 1'b1;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  clk_en;

    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cpu_ratio_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .upper_present(upper_present),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .clk_en(clk_en)
    );

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
            report();
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] a_of(int base, int c);
        return 12'(base + c * 'h14);
    endfunction

    task automatic bus_write(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic measure(int c, output int per);
        int n = 0;
        per = -1;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (clk_en[c]) break;
        end
        for (int k = 1; k < 200; k++) begin
            @(negedge clk);
            if (clk_en[c]) begin n = k; break; end
        end
        if (n > 0) per = n;
    endtask

    task automatic wait_stable(int c, string tag);
        logic [31:0] d;
        int ok = 0;
        for (int k = 0; k < 500; k++) begin
            bus_read(12'hC94, d);
            if (d[c]) begin ok = 1; break; end
        end
        chk({tag, " stable reached"}, ok, 1);
    endtask

    task automatic do_reload(int c, int ratio, string tag);
        logic [31:0] d;
        bus_write(a_of('h278, c), 32'(ratio));
        bus_write(a_of('h280, c), 32'h0100_0000);
        bus_write(a_of('h284, c), 32'h0001_0000);
        bus_read(12'hC94, d);
        chk("R4 stable cleared after request", int'(d[c]), 0);
        wait_stable(c, tag);
        bus_write(a_of('h284, c), 32'h0);
        bus_read(12'hC94, d);
        chk("R6 stable kept after request clear", int'(d[c]), 1);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        int p;
        for (int c = 0; c < 2; c++) begin
            bus_read(a_of('h278, c), d); chk("R10 shadow ratio at reset", int'(d[5:0]), 1);
            bus_read(a_of('h280, c), d); chk("R10 force at reset", int'(d), 0);
            bus_read(a_of('h284, c), d); chk("R10 request at reset", int'(d), 0);
            measure(c, p); chk("R10 period at reset", p, 1);
        end
        bus_read(12'hC94, d); chk("R10 status at reset", int'(d), 3);
    endtask

    task automatic t_shadow_only();
        logic [31:0] d;
        int p;
        bus_write(a_of('h278, 0), 32'd5);
        bus_read(a_of('h278, 0), d); chk("R1 ratio readback", int'(d), 5);
        measure(0, p); chk("R2 period unchanged by shadow write", p, 1);
        bus_write(a_of('h280, 0), 32'h0100_0000);
        bus_read(a_of('h280, 0), d); chk("R1 force bit 24 readback", int'(d), 32'h0100_0000);
    endtask

    task automatic t_reload();
        int p;
        do_reload(0, 5, "R3");
        measure(0, p); chk("R3 period after reload to 5", p, 5);
        measure(1, p); chk("R8 cluster1 untouched", p, 1);
    endtask

    task automatic t_noforce();
        logic [31:0] d;
        int p;
        bus_write(a_of('h280, 1), 32'h0);
        bus_write(a_of('h278, 1), 32'd3);
        bus_write(a_of('h284, 1), 32'h0001_0000);
        bus_read(a_of('h284, 1), d); chk("R1 request bit 16 readback", int'(d), 32'h0001_0000);
        repeat (10) @(negedge clk);
        bus_read(12'hC94, d); chk("R5 stable kept without force", int'(d[1]), 1);
        measure(1, p); chk("R5 period unchanged without force", p, 1);
        bus_write(a_of('h284, 1), 32'h0);
    endtask

    task automatic t_clamp();
        int p;
        do_reload(0, 0, "R7");
        measure(0, p); chk("R7 ratio 0 acts as 1", p, 1);
        do_reload(0, 40, "R7");
        measure(0, p); chk("R7 ratio 40 acts as 32", p, 32);
    endtask

    task automatic t_indep();
        int p;
        do_reload(1, 4, "R8");
        measure(1, p); chk("R8 cluster1 period 4", p, 4);
        measure(0, p); chk("R8 cluster0 period kept at 32", p, 32);
    endtask

    task automatic t_absent();
        logic [31:0] d;
        int hits = 0;
        upper_present = 1'b0;
        bus_read(a_of('h278, 1), d); chk("R9 absent ratio reads 0", int'(d), 0);
        bus_read(12'hC94, d); chk("R9 absent status bit reads 0", int'(d[1]), 0);
        bus_write(a_of('h278, 1), 32'd7);
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (clk_en[1]) hits++;
        end
        chk("R9 absent clock enable low", hits, 0);
        upper_present = 1'b1;
        bus_read(a_of('h278, 1), d); chk("R9 write ignored while absent", int'(d), 4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_shadow_only();
        t_reload();
        t_noforce();
        t_clamp();
        t_indep();
        t_absent();
        done = 1;
        report();
    end
endmodule